// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the receive-side character store of a UART. Each incoming character arrives on a single write port, from the deserializer or from an internal loopback path, together with four error flags. The character and its flags are kept as one entry in a circular buffer. Software reads the buffer through a data-register read strobe. The entry at the head is always presented on the read outputs. A read strobe pops it and copies its error flags into a receive status register. A separate strobe clears that register.

The usable depth changes at run time. It is 16 entries while the queue is switched on and a single entry while it is switched off. Writing the line-control enable with a value different from the current one flushes the buffer. A receive interrupt request follows the entry count against a trigger level, which is 1 by default. The request is raised when a write brings the count to the trigger level. It is dropped when a read leaves the count exactly one below that level.

Top module: `uart_rx_queue`

## Requirements
- R1: After synchronous reset the queue is in single-entry mode with `q_empty`=1, `q_full`=0, `can_accept`=1, `rx_irq`=0 and `rx_status`=0.
- R2: With the queue switched on, 16 writes are accepted. `q_full` rises on the 16th write and not before. Entries come out in the order they were written.
- R3: With the queue switched off, the usable depth is one. A single write sets `q_full`=1 and `can_accept`=0.
- R4: A write while `can_accept`=0 is dropped. The count, the pointers and the stored entries stay unchanged, so later reads return only the earlier characters.
- R5: A read while empty still presents the entry at the head position and clears `q_full`. It does not change the count or move the head, and `q_empty` stays 1.
- R6: `q_empty` rises when a read leaves the count at zero. `can_accept` is 1 exactly while the count is below the usable depth.
- R7: `rx_irq` is set when the count after a write equals the trigger level (default 1). It is cleared when the count after a read, plus one, equals the trigger level.
- R8: A line-control write whose enable differs from the current mode flushes the queue: count and head go to 0, `q_empty`=1 and `q_full`=0. Any read or write in the same cycle is cancelled. A line-control write with the same enable value changes nothing.
- R9: A read copies the popped entry's error flags into `rx_status`. The flag positions are bit0 framing, bit1 parity, bit2 break and bit3 overrun, the same as `wr_err`. A `status_clr` strobe sets `rx_status` to 0 and takes priority over a read in the same cycle.
- R10: When read and write happen in the same cycle, the read returns the old head. The write is accepted only if the count before that cycle was below the usable depth.
- R11: In the 16-entry mode the head and write slot wrap modulo 16, so ordering holds across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Incoming character strobe |
| wr_data | input | 8 | Incoming character |
| wr_err | input | 4 | Incoming error flags (framing, parity, break, overrun from bit0) |
| rd_en | input | 1 | Data-register read strobe (pops head) |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_fifo_en | input | 1 | Queue enable value carried by the line-control write |
| status_clr | input | 1 | Receive status clear strobe |
| rd_data | output | 8 | Character at the head |
| rd_err | output | 4 | Error flags at the head |
| rx_status | output | 4 | Flags of the last popped entry |
| q_full | output | 1 | Full flag |
| q_empty | output | 1 | Empty flag |
| can_accept | output | 1 | Count below usable depth |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the 16-entry queue exactly. A design with an off-by-one full test would raise `q_full` at 15 or accept a 17th character. A 17th character that gets through shows up as an extra read value. Reads from an empty queue check that the head stays put. A design that decremented past zero or moved the head would return a different stale entry, or lose `q_empty` on the next write. The bench also flushes the queue with the mode toggle while a write is pending, and issues a same-mode line-control write. A design that ignored the toggle, or flushed on every line-control write, would report the wrong empty state. Simultaneous read and write at full and at one entry show whether acceptance uses the pre-cycle count.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int CHAR_W = 8;
    localparam int FLAG_W = 4;

    // Packed: first member is the most significant bit.
    typedef struct packed {
        logic overrun;   // bit3
        logic brk;       // bit2
        logic parity;    // bit1
        logic framing;   // bit0
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t              flags;
        logic [CHAR_W-1:0]      chr;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    // Slot index wrapped by a power-of-two mask.
    function automatic logic [7:0] wrap_idx(input logic [7:0] idx, input logic [7:0] mask);
        return idx & mask;
    endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [DEPTH_LOG2-1:0] wr_slot,
    input  rx_entry_t             wr_entry,
    input  logic [DEPTH_LOG2-1:0] rd_slot,
    output rx_entry_t             rd_entry
);
    localparam int SLOTS = 1 << DEPTH_LOG2;

    rx_entry_t cells [SLOTS];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    cells[g] <= '0;
                end else if (we && (wr_slot == DEPTH_LOG2'(g))) begin
                    cells[g] <= wr_entry;
                end
            end
        end
    endgenerate

    assign rd_entry = cells[rd_slot];

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4,
    parameter int TRIG_LEVEL = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  lcr_wr,
    input  logic                  lcr_fifo_en,
    output logic                  we,
    output logic [DEPTH_LOG2-1:0] wr_slot,
    output logic [DEPTH_LOG2-1:0] head,
    output logic                  rd_take,
    output logic                  full,
    output logic                  empty,
    output logic                  can_accept,
    output logic                  rx_irq
);
    localparam int PTR_W = DEPTH_LOG2;
    localparam int CNT_W = DEPTH_LOG2 + 1;
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [CNT_W:0] TRIG_V = (CNT_W+1)'(TRIG_LEVEL);

    logic             fifo_on, fifo_on_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [PTR_W-1:0] pos_n;
    logic             full_n, empty_n, irq_n;
    logic [CNT_W-1:0] depth_eff;
    logic [PTR_W-1:0] mask;
    logic             flush;

    assign depth_eff  = fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);
    assign mask       = fifo_on ? PTR_W'(DEPTH - 1) : '0;
    assign can_accept = (cnt < depth_eff);
    assign flush      = lcr_wr && (lcr_fifo_en != fifo_on);
    assign rd_take    = rd_en && !flush;

    always_comb begin
        fifo_on_n = fifo_on;
        cnt_n     = cnt;
        pos_n     = head;
        full_n    = full;
        empty_n   = empty;
        irq_n     = rx_irq;
        we        = 1'b0;
        wr_slot   = '0;
        if (flush) begin
            fifo_on_n = lcr_fifo_en;
            cnt_n     = '0;
            pos_n     = '0;
            full_n    = 1'b0;
            empty_n   = 1'b1;
        end else begin
            if (rd_en) begin
                full_n = 1'b0;
                if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                    pos_n = (head + 1'b1) & mask;
                end
                if (cnt_n == '0) empty_n = 1'b1;
                if (({1'b0, cnt_n} + 1'b1) == TRIG_V) irq_n = 1'b0;
            end
            if (wr_en && can_accept) begin
                we      = 1'b1;
                wr_slot = (pos_n + PTR_W'(cnt_n)) & mask;
                cnt_n   = cnt_n + 1'b1;
                empty_n = 1'b0;
                if (cnt_n == depth_eff) full_n = 1'b1;
                if ({1'b0, cnt_n} == TRIG_V) irq_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_on <= 1'b0;
            cnt     <= '0;
            head    <= '0;
            full    <= 1'b0;
            empty   <= 1'b1;
            rx_irq  <= 1'b0;
        end else begin
            fifo_on <= fifo_on_n;
            cnt     <= cnt_n;
            head    <= pos_n;
            full    <= full_n;
            empty   <= empty_n;
            rx_irq  <= irq_n;
        end
    end

    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (rst)
        full |-> (cnt == depth_eff)) else $error("full without depth"); // R2
    AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        empty |-> (cnt == '0)) else $error("empty with entries"); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= depth_eff) else $error("count overflow"); // R4
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !can_accept && !rd_en && !lcr_wr) |=> (cnt == $past(cnt) && head == $past(head)))
        else $error("write while full changed state"); // R4
    AST_FLUSH_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0 && empty && !full && head == '0)) else $error("toggle did not flush"); // R8
    AST_IRQ_ON_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && can_accept && !rd_en && !flush && ({1'b0, cnt} + 1'b1 == TRIG_V)) |=> rx_irq)
        else $error("irq not raised at trigger"); // R7

endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status
    import uart_rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  logic      clr,
    input  rx_flags_t flags_in,
    output rx_flags_t status
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            status <= '0;
        end else if (capture) begin
            status <= flags_in;
        end
    end

    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (status == '0)) else $error("status not cleared"); // R9

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH_LOG2 = 4,
    parameter int TRIG_LEVEL = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_err,
    input  logic              rd_en,
    input  logic              lcr_wr,
    input  logic              lcr_fifo_en,
    input  logic              status_clr,
    output logic [CHAR_W-1:0] rd_data,
    output logic [FLAG_W-1:0] rd_err,
    output logic [FLAG_W-1:0] rx_status,
    output logic              q_full,
    output logic              q_empty,
    output logic              can_accept,
    output logic              rx_irq
);
    logic                  we, rd_take;
    logic [DEPTH_LOG2-1:0] wr_slot, head;
    rx_entry_t             in_entry, head_entry;
    rx_flags_t             status_q;

    assign in_entry.chr   = wr_data;
    assign in_entry.flags = rx_flags_t'(wr_err);

    uart_rxq_ctrl #(
        .DEPTH_LOG2 (DEPTH_LOG2),
        .TRIG_LEVEL (TRIG_LEVEL)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .lcr_wr      (lcr_wr),
        .lcr_fifo_en (lcr_fifo_en),
        .we          (we),
        .wr_slot     (wr_slot),
        .head        (head),
        .rd_take     (rd_take),
        .full        (q_full),
        .empty       (q_empty),
        .can_accept  (can_accept),
        .rx_irq      (rx_irq)
    );

    uart_rxq_store #(
        .DEPTH_LOG2 (DEPTH_LOG2)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (we),
        .wr_slot  (wr_slot),
        .wr_entry (in_entry),
        .rd_slot  (head),
        .rd_entry (head_entry)
    );

    uart_rxq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .capture  (rd_take),
        .clr      (status_clr),
        .flags_in (head_entry.flags),
        .status   (status_q)
    );

    assign rd_data   = head_entry.chr;
    assign rd_err    = head_entry.flags;
    assign rx_status = status_q;

    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty)) else $error("full and empty together"); // R6

endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, lcr_wr = 1'b0, lcr_fifo_en = 1'b0, status_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [3:0] wr_err = '0;
    logic [7:0] rd_data;
    logic [3:0] rd_err, rx_status;
    logic       q_full, q_empty, can_accept, rx_irq;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] got_d;
    logic [3:0] got_e;

    always #10 clk = ~clk;

    uart_rx_queue i_uart_rx_queue (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .lcr_wr(lcr_wr), .lcr_fifo_en(lcr_fifo_en), .status_clr(status_clr),
        .rd_data(rd_data), .rd_err(rd_err), .rx_status(rx_status), .q_full(q_full),
        .q_empty(q_empty), .can_accept(can_accept), .rx_irq(rx_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; lcr_wr = 0; status_clr = 0;
    endtask

    task automatic push(input logic [7:0] d, input logic [3:0] e);
        wr_en = 1; wr_data = d; wr_err = e;
        step();
    endtask

    task automatic pop();
        rd_en = 1; got_d = rd_data; got_e = rd_err;
        step();
    endtask

    task automatic set_mode(input bit on);
        lcr_wr = 1; lcr_fifo_en = on;
        step();
    endtask

    task automatic t_reset();
        check(q_empty == 1, "R1 empty", q_empty, 1);
        check(q_full == 0, "R1 full", q_full, 0);
        check(can_accept == 1, "R1 can_accept", can_accept, 1);
        check(rx_irq == 0, "R1 irq", rx_irq, 0);
        check(rx_status == 0, "R1 status", rx_status, 0);
    endtask

    task automatic t_single();
        push(8'hA5, 4'h0);
        check(q_full == 1, "R3 full after one", q_full, 1);
        check(can_accept == 0, "R3 can_accept", can_accept, 0);
        check(rx_irq == 1, "R7 irq set", rx_irq, 1);
        push(8'h3C, 4'h0);
        pop();
        check(got_d == 8'hA5, "R4 dropped write", got_d, 8'hA5);
        check(q_empty == 1, "R6 empty after last read", q_empty, 1);
        check(q_full == 0, "R6 full cleared", q_full, 0);
        check(rx_irq == 0, "R7 irq cleared", rx_irq, 0);
        pop();
        check(got_d == 8'hA5, "R5 stale head", got_d, 8'hA5);
        check(q_empty == 1 && can_accept == 1, "R5 empty kept", q_empty, 1);
    endtask

    task automatic t_status();
        status_clr = 1; step();
        push(8'h5A, 4'b0101);
        pop();
        check(got_d == 8'h5A && got_e == 4'b0101, "R9 entry flags", got_e, 4'b0101);
        check(rx_status == 4'b0101, "R9 status captured", rx_status, 4'b0101);
        status_clr = 1; step();
        check(rx_status == 0, "R9 status cleared", rx_status, 0);
    endtask

    task automatic t_toggle_on();
        push(8'h11, 4'h0);
        set_mode(1);
        check(q_empty == 1 && q_full == 0, "R8 flush on toggle", q_empty, 1);
        check(can_accept == 1, "R8 accept after flush", can_accept, 1);
    endtask

    task automatic t_fifo16();
        for (int i = 0; i < 16; i++) begin
            push(8'(i * 7 + 1), 4'h0);
            if (i == 0) check(rx_irq == 1, "R7 irq at trigger", rx_irq, 1);
            if (i == 14) check(q_full == 0 && can_accept == 1, "R2 not full at 15", q_full, 0);
        end
        check(q_full == 1 && can_accept == 0, "R2 full at 16", q_full, 1);
        push(8'hEE, 4'h0);
        for (int i = 0; i < 16; i++) begin
            pop();
            check(got_d == 8'(i * 7 + 1), "R2 order", got_d, i * 7 + 1);
            if (i == 0) check(q_full == 0, "R2 full cleared by read", q_full, 0);
            if (i == 14) check(rx_irq == 1, "R7 irq held at one", rx_irq, 1);
        end
        check(q_empty == 1 && rx_irq == 0, "R4 extra write dropped", q_empty, 1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 10; i++) push(8'(8'h40 + i), 4'h0);
        for (int i = 0; i < 10; i++) pop();
        for (int i = 0; i < 12; i++) push(8'(8'h80 + i), 4'(i));
        for (int i = 0; i < 12; i++) begin
            pop();
            check(got_d == 8'(8'h80 + i) && got_e == 4'(i), "R11 wrap order", got_d, 8'h80 + i);
        end
        check(q_empty == 1, "R11 empty after wrap", q_empty, 1);
    endtask

    task automatic t_simul();
        push(8'h21, 4'h0);
        wr_en = 1; wr_data = 8'h22; wr_err = 0; rd_en = 1; got_d = rd_data;
        step();
        check(got_d == 8'h21, "R10 read old head", got_d, 8'h21);
        check(q_empty == 0 && q_full == 0, "R10 one entry left", q_empty, 0);
        pop();
        check(got_d == 8'h22 && q_empty == 1, "R10 new entry", got_d, 8'h22);
        for (int i = 0; i < 16; i++) push(8'(8'hC0 + i), 4'h0);
        wr_en = 1; wr_data = 8'hFF; rd_en = 1; got_d = rd_data;
        step();
        check(got_d == 8'hC0 && can_accept == 1, "R10 full read+write", got_d, 8'hC0);
        for (int i = 1; i < 16; i++) pop();
        check(got_d == 8'hCF && q_empty == 1, "R10 write at full dropped", got_d, 8'hCF);
    endtask

    task automatic t_same_mode();
        push(8'h61, 4'h0);
        push(8'h62, 4'h0);
        set_mode(1);
        check(q_empty == 0, "R8 same mode keeps data", q_empty, 0);
        pop();
        check(got_d == 8'h61, "R8 same mode head", got_d, 8'h61);
    endtask

    task automatic t_toggle_cancel();
        lcr_wr = 1; lcr_fifo_en = 0; wr_en = 1; wr_data = 8'h77;
        step();
        check(q_empty == 1 && can_accept == 1, "R8 toggle cancels write", q_empty, 1);
        push(8'h78, 4'h0);
        check(q_full == 1, "R3 depth one again", q_full, 1);
        pop();
        check(got_d == 8'h78, "R8 cancelled write absent", got_d, 8'h78);
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_status();
        t_toggle_on();
        t_fifo16();
        t_wrap();
        t_simul();
        t_same_mode();
        t_toggle_cancel();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule